// File: doc/BRIEF.md
# NAND Page ECC Parity Accumulator

This block sits beside the data path of a NAND flash interface. It watches every data beat moving to or from the flash and folds each beat into Hamming-style parity. The result lets software find and correct one flipped bit per byte lane per page.

There are two accumulators. The main one covers a page of up to 512 beats. The spare one covers up to 16 beats of the spare area. Each has its own lock bit. Locking an accumulator freezes its parity so software can read it or write it back to the spare area. A single init command clears both accumulators together with their beat counters.

The flash bus is 8 or 16 bits wide. Each byte lane has its own parity. The results are packed into three 32-bit words, and the packing depends on the bus width.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset, all three result words are zero and both accumulators are locked. Beats seen in this state change nothing.
- R2: A control write with bit 4 set clears both accumulators and both beat counters. All three result words read zero in the cycle after the write.
- R3: Control bit 5 is the main lock. A control write loads it, and the new value applies to beats from the next cycle on. While it is 0, each valid beat updates the main parity. While it is 1, the main result words do not change.
- R4: Control bit 6 is the spare lock. It gates the spare accumulator in the same way, independently of the main lock.
- R5: ECC byte 1 of each lane holds column parity over the lane's 8 data bits d, XOR-accumulated over beats. From bit 5 down to bit 0 it holds: ^(d&F0h), ^(d&0Fh), ^(d&CCh), ^(d&33h), ^(d&AAh), ^(d&55h). Bits 7:6 are zero.
- R6: Main line parity is held in ECC bytes 2 to 4 of each lane, read as one 24-bit field. For each bit k (0 to 8) of the beat index, the lane's row parity (XOR of its 8 bits) is XORed into field bit 2k+1 if index bit k is 1, and into field bit 2k if it is 0. Field bits 23:18 are zero. The index counts 0 to 511 and then wraps.
- R7: Spare line parity follows the same rule with a 4-bit index (0 to 15, wrapping). It fills ECC byte 2, and the spare area has only ECC bytes 1 and 2.
- R8: In 16-bit mode, main word 0 holds, from the low byte up: byte 1 of lane 0, byte 1 of lane 1, byte 2 of lane 0, byte 2 of lane 1. Main word 1 holds bytes 3 and 4 in the same pattern. The spare word holds spare bytes 1 and 2 in the same pattern. Lane 0 is data[7:0] and lane 1 is data[15:8].
- R9: In 8-bit mode, only data[7:0] is accumulated, and bits 15:8 and 31:24 of every result word read zero.
- R10: If init and a valid beat arrive in the same cycle, the beat is not accumulated and does not advance either counter.
- R11: The bus width select changes only while both accumulators are locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 8 | Control data: bit 4 init, bit 5 main lock, bit 6 spare lock |
| bus16_i | input | 1 | 1 selects the 16-bit bus, 0 selects the 8-bit bus |
| beat_vld_i | input | 1 | A data beat is present this cycle |
| beat_data_i | input | 16 | Beat data |
| main0_o | output | 32 | Main result word 0 (ECC bytes 1 and 2) |
| main1_o | output | 32 | Main result word 1 (ECC bytes 3 and 4) |
| spare_o | output | 32 | Spare result word (ECC bytes 1 and 2) |

## Verification
The freeze properties assume the width select stays put whenever an accumulator is locked. Masking of lane 1 follows the width select, so a width change would alter a frozen word; the width rule itself is checked as its own property. The stimulus changes the width only after a control write has locked both areas, and it unlocks again only after the new width is settled. Control writes are never issued with reserved bits set.

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc #(
  parameter int MAIN_BEATS  = 512,
  parameter int SPARE_BEATS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr_i,
  input  logic [7:0]  ctrl_wdata_i,
  input  logic        bus16_i,
  input  logic        beat_vld_i,
  input  logic [15:0] beat_data_i,
  output logic [31:0] main0_o,
  output logic [31:0] main1_o,
  output logic [31:0] spare_o
);
  localparam int MIDX = $clog2(MAIN_BEATS);
  localparam int SIDX = $clog2(SPARE_BEATS);
  localparam int COLW = 6;
  localparam int MLW  = 2 * MIDX;
  localparam int SLW  = 2 * SIDX;
  localparam int INIT_BIT  = 4;
  localparam int MLOCK_BIT = 5;
  localparam int SLOCK_BIT = 6;

  function automatic logic [COLW-1:0] col_par(input logic [7:0] d);
    logic [COLW-1:0] r;
    r = '0;
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < 8; i++)
        if (((i >> j) & 1) == 1) r[2*j+1] = r[2*j+1] ^ d[i];
        else                     r[2*j]   = r[2*j]   ^ d[i];
    return r;
  endfunction

  function automatic logic [31:0] line_mask(input logic [31:0] idx, input int n);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 16; k++)
      if (k < n) r[2*k + int'(idx[k])] = 1'b1;
    return r;
  endfunction

  logic            main_lk, spare_lk;
  logic [MIDX-1:0] main_cnt;
  logic [SIDX-1:0] spare_cnt;
  logic            init, main_upd, spare_upd;
  logic [31:0]     mmask, smask;
  logic [31:0]     m_vec [2];
  logic [15:0]     s_vec [2];
  logic            unused_ctrl;

  assign init      = ctrl_wr_i & ctrl_wdata_i[INIT_BIT];
  assign main_upd  = beat_vld_i & ~main_lk  & ~init;
  assign spare_upd = beat_vld_i & ~spare_lk & ~init;
  assign mmask     = line_mask(32'(main_cnt), MIDX);
  assign smask     = line_mask(32'(spare_cnt), SIDX);
  assign unused_ctrl = ^{ctrl_wdata_i[7], ctrl_wdata_i[3:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_lk   <= 1'b1;
      spare_lk  <= 1'b1;
      main_cnt  <= '0;
      spare_cnt <= '0;
    end else begin
      if (ctrl_wr_i) begin
        main_lk  <= ctrl_wdata_i[MLOCK_BIT];
        spare_lk <= ctrl_wdata_i[SLOCK_BIT];
      end
      if (init) begin
        main_cnt  <= '0;
        spare_cnt <= '0;
      end else begin
        if (main_upd)  main_cnt  <= main_cnt + 1'b1;
        if (spare_upd) spare_cnt <= spare_cnt + 1'b1;
      end
    end
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [7:0]      d;
    logic            act, rp;
    logic [COLW-1:0] mcol, scol;
    logic [MLW-1:0]  mline;
    logic [SLW-1:0]  sline;

    assign d   = beat_data_i[8*l +: 8];
    assign act = (l == 0) || bus16_i;
    assign rp  = ^d;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mcol <= '0; mline <= '0; scol <= '0; sline <= '0;
      end else if (init) begin
        mcol <= '0; mline <= '0; scol <= '0; sline <= '0;
      end else begin
        if (main_upd && act) begin
          mcol  <= mcol ^ col_par(d);
          mline <= mline ^ (mmask[MLW-1:0] & {MLW{rp}});
        end
        if (spare_upd && act) begin
          scol  <= scol ^ col_par(d);
          sline <= sline ^ (smask[SLW-1:0] & {SLW{rp}});
        end
      end
    end

    assign m_vec[l] = 32'({mline, 8'(mcol)});
    assign s_vec[l] = 16'({sline, 8'(scol)});
  end

  logic [31:0] m1, s1;
  assign m1 = bus16_i ? m_vec[1] : 32'd0;
  assign s1 = bus16_i ? 32'(s_vec[1]) : 32'd0;

  assign main0_o = {m1[15:8],  m_vec[0][15:8],  m1[7:0],   m_vec[0][7:0]};
  assign main1_o = {m1[31:24], m_vec[0][31:24], m1[23:16], m_vec[0][23:16]};
  assign spare_o = {s1[15:8],  s_vec[0][15:8],  s1[7:0],   s_vec[0][7:0]};
endmodule

module nand_ecc_acc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_wr_i,
  input logic [7:0]  ctrl_wdata_i,
  input logic        bus16_i,
  input logic        main_lk,
  input logic        spare_lk,
  input logic [31:0] main0_o,
  input logic [31:0] main1_o,
  input logic [31:0] spare_o
);
  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && ctrl_wdata_i[4]) |=> (main0_o == 32'd0 && main1_o == 32'd0 && spare_o == 32'd0));

  // R3
  main_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_lk && !(ctrl_wr_i && ctrl_wdata_i[4])) |=>
      ($stable(bus16_i) -> ($stable(main0_o) && $stable(main1_o))));

  // R4
  spare_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_lk && !(ctrl_wr_i && ctrl_wdata_i[4])) |=>
      ($stable(bus16_i) -> $stable(spare_o)));

  // R5
  col_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main0_o[7:6] == 2'b00 && main0_o[15:14] == 2'b00 && spare_o[7:6] == 2'b00);

  // R9
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus16_i |-> (main0_o[15:8] == 8'd0 && main0_o[31:24] == 8'd0 &&
                  main1_o[15:8] == 8'd0 && main1_o[31:24] == 8'd0 &&
                  spare_o[15:8] == 8'd0 && spare_o[31:24] == 8'd0));

  // R11
  width_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus16_i) |-> (main_lk && spare_lk));
endmodule

bind nand_ecc_acc nand_ecc_acc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
  .bus16_i(bus16_i), .main_lk(main_lk), .spare_lk(spare_lk),
  .main0_o(main0_o), .main1_o(main1_o), .spare_o(spare_o)
);

// File: tb/nand_ecc_acc_tb.sv
module nand_ecc_acc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr_i = 1'b0;
  logic [7:0]  ctrl_wdata_i = '0;
  logic        bus16_i = 1'b1;
  logic        beat_vld_i = 1'b0;
  logic [15:0] beat_data_i = '0;
  logic [31:0] main0_o, main1_o, spare_o;

  int checks = 0;
  int errors = 0;

  logic [5:0]  e_mcol [2];
  logic [5:0]  e_scol [2];
  logic [17:0] e_mline [2];
  logic [7:0]  e_sline [2];
  int          e_mcnt, e_scnt;
  bit          e_mlk, e_slk;

  always #5 clk = ~clk;

  nand_ecc_acc u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
    .bus16_i(bus16_i), .beat_vld_i(beat_vld_i), .beat_data_i(beat_data_i),
    .main0_o(main0_o), .main1_o(main1_o), .spare_o(spare_o)
  );

  function automatic logic [5:0] colp(input logic [7:0] d);
    return {^(d & 8'hF0), ^(d & 8'h0F), ^(d & 8'hCC), ^(d & 8'h33), ^(d & 8'hAA), ^(d & 8'h55)};
  endfunction

  task automatic model_clear();
    for (int l = 0; l < 2; l++) begin
      e_mcol[l] = '0; e_scol[l] = '0; e_mline[l] = '0; e_sline[l] = '0;
    end
    e_mcnt = 0; e_scnt = 0;
  endtask

  task automatic model_beat(input logic [15:0] data);
    for (int l = 0; l < 2; l++) begin
      logic [7:0] d;
      d = data[8*l +: 8];
      if (l == 1 && !bus16_i) continue;
      if (!e_mlk) begin
        e_mcol[l] ^= colp(d);
        for (int k = 0; k < 9; k++)
          if (e_mcnt[k]) e_mline[l][2*k+1] ^= ^d; else e_mline[l][2*k] ^= ^d;
      end
      if (!e_slk) begin
        e_scol[l] ^= colp(d);
        for (int k = 0; k < 4; k++)
          if (e_scnt[k]) e_sline[l][2*k+1] ^= ^d; else e_sline[l][2*k] ^= ^d;
      end
    end
    if (!e_mlk) e_mcnt = (e_mcnt + 1) % 512;
    if (!e_slk) e_scnt = (e_scnt + 1) % 16;
  endtask

  function automatic logic [7:0] hi(input logic [7:0] v);
    return bus16_i ? v : 8'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, main0_o, {hi(8'(e_mline[1][7:0])), e_mline[0][7:0], hi({2'b0, e_mcol[1]}), {2'b0, e_mcol[0]}}, "main0");
    check(req, main1_o, {hi({6'b0, e_mline[1][17:16]}), {6'b0, e_mline[0][17:16]}, hi(e_mline[1][15:8]), e_mline[0][15:8]}, "main1");
    check(req, spare_o, {hi(e_sline[1]), e_sline[0], hi({2'b0, e_scol[1]}), {2'b0, e_scol[0]}}, "spare");
  endtask

  // control write; optional simultaneous beat (R10)
  task automatic ctrl(input bit ini, input bit ml, input bit sl, input bit vld, input logic [15:0] data);
    ctrl_wr_i = 1'b1;
    ctrl_wdata_i = {1'b0, sl, ml, ini, 4'b0};
    beat_vld_i = vld;
    beat_data_i = data;
    if (ini) model_clear();
    else if (vld) model_beat(data);
    e_mlk = ml; e_slk = sl;
    @(negedge clk);
    ctrl_wr_i = 1'b0; ctrl_wdata_i = '0; beat_vld_i = 1'b0;
  endtask

  task automatic beats(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      d = 16'((i + seed) * 16'h2F1B) ^ 16'((i << 7) + seed * 3);
      beat_vld_i = 1'b1;
      beat_data_i = d;
      model_beat(d);
      @(negedge clk);
    end
    beat_vld_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", main0_o, 32'd0, "reset main0");
    check("R1", main1_o, 32'd0, "reset main1");
    check("R1", spare_o, 32'd0, "reset spare");
    beats(5, 1);
    check_all("R1 R3 locked after reset");
  endtask

  task automatic t_main16();
    ctrl(1, 0, 1, 0, 0);
    check_all("R2 init");
    beats(40, 7);
    check_all("R3 R5 R6 R8 main 16-bit");
    beats(477, 9);
    check_all("R6 main counter wrap");
    ctrl(0, 1, 1, 0, 0);
    beats(12, 3);
    check_all("R3 main frozen");
  endtask

  task automatic t_spare();
    ctrl(1, 1, 0, 0, 0);
    beats(11, 21);
    check_all("R4 R7 spare only");
    beats(9, 33);
    check_all("R7 spare counter wrap");
    ctrl(0, 0, 1, 0, 0);
    beats(6, 40);
    check_all("R4 spare frozen, main live");
  endtask

  task automatic t_narrow();
    ctrl(0, 1, 1, 0, 0);
    @(negedge clk);
    bus16_i = 1'b0;   // R11: changed while both locked
    @(negedge clk);
    ctrl(1, 0, 0, 0, 0);
    beats(30, 55);
    check_all("R9 R11 8-bit packing");
    ctrl(0, 1, 1, 0, 0);
    @(negedge clk);
    bus16_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_init_prio();
    ctrl(1, 0, 0, 0, 0);
    beats(6, 70);
    ctrl(1, 0, 0, 1, 16'hA5C3);
    check_all("R10 R2 init beats beat");
    beats(1, 90);
    check_all("R10 counter restarted at 0");
  endtask

  initial begin
    model_clear();
    e_mlk = 1; e_slk = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_main16();
    t_spare();
    t_narrow();
    t_init_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule